// File: doc/BRIEF.md
# Filtered White Noise Generator

This block produces a stream of band-limited noise samples for use as stimulus in link simulations. A 32-bit maximal-length shift register acts as a uniform white source. A first-order recursive low-pass filter shapes its samples, and the filter stands in for a single-pole continuous response 1/(sτ+1). The discrete filter replaces the derivative with a backward difference, so each new output is y[n] = α·x[n] + (1−α)·y[n−1], with α = T/(τ+T), where T is the sample period and τ is the wanted time constant.

Below the corner the output spectrum is flat, like the source. Above the corner it falls off along a one-pole slope towards 1/f². Software or a sequencer picks α to place the corner, then pulses the sample strobe once per wanted sample. Each strobe yields one output word, and a valid flag marks it one clock later.

Top module: `nz_filtered_noise`

## Requirements
- R1: The source is a 32-bit register. On each accepted strobe it shifts left by one, and bit 0 takes the XOR of bits 31, 21, 1 and 0. The sample x used by that strobe is bits [31:16] of the register before the shift, read as a two's-complement value.
- R2: Synchronous reset clears the output word to zero, clears the valid flag, and loads the source with the non-zero seed 0xACE12468.
- R3: On a strobe the new output is floor((α·x + (65536−α)·y_prev + 32768) / 65536), clamped to the range −32768..32767. Here α is the unsigned 16-bit coefficient, read as a fraction of 65536, and y_prev is the previous output.
- R4: The valid flag is high in exactly the clock that follows a cycle with the strobe high. It is low after any cycle without the strobe.
- R5: In a cycle without the strobe, neither the output word nor the source changes. The sequence resumes exactly where it stopped.
- R6: A strobe with α = 0 leaves the output word unchanged, while the source still advances by one step.
- R7: The coefficient is sampled only in a strobe cycle. Changing it between strobes has no effect on any output.
- R8: A reset in the middle of a run restarts the identical sample sequence from the seed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sample_en | input | 1 | Strobe: take one white sample and update the filter |
| alpha | input | 16 | Filter gain α, unsigned fraction of 65536 |
| noise_o | output | 16 | Filtered noise sample, signed Q1.15 |
| valid_o | output | 1 | High one clock after each strobe |

## Verification
The hardest case to reach from the ports is one where the source has moved on but the output has not. That happens with α = 0, and also with strobe gaps while the coefficient changes. A stuck or skipped source step shows up only in later samples. To expose it, the stimulus runs a long stretch at α = 0 and toggles the coefficient on idle cycles. It then switches to a non-zero α, so every later output depends on exactly how many source steps took place. Sweeps over several coefficients, from the smallest to the largest, exercise the rounding at both ends of the gain range. Each output is compared with an arithmetic model in the bench.

// File: rtl/nz_pkg.sv
package nz_pkg;
    localparam int unsigned NZ_OUT_W  = 16;
    localparam int unsigned NZ_COEF_W = 16;
    localparam int unsigned NZ_SRC_W  = 32;
    localparam logic [31:0] NZ_SEED   = 32'hACE1_2468;
    // feedback taps of the maximal-length register (bit indices)
    localparam int unsigned NZ_TAP_A  = 31;
    localparam int unsigned NZ_TAP_B  = 21;
    localparam int unsigned NZ_TAP_C  = 1;
    localparam int unsigned NZ_TAP_D  = 0;
endpackage

// File: rtl/nz_lfsr_src.sv
module nz_lfsr_src #(
    parameter int unsigned SRC_W = nz_pkg::NZ_SRC_W,
    parameter int unsigned OUT_W = nz_pkg::NZ_OUT_W,
    parameter logic [SRC_W-1:0] SEED = SRC_W'(nz_pkg::NZ_SEED),
    parameter int unsigned TAP_A = nz_pkg::NZ_TAP_A,
    parameter int unsigned TAP_B = nz_pkg::NZ_TAP_B,
    parameter int unsigned TAP_C = nz_pkg::NZ_TAP_C,
    parameter int unsigned TAP_D = nz_pkg::NZ_TAP_D
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    adv_i,
    output logic signed [OUT_W-1:0] sample_o,
    output logic [SRC_W-1:0]        state_o
);
    typedef struct packed {
        logic [SRC_W-1:0] s;
    } src_t;

    src_t st_d, st_q;
    logic fb;

    always_comb begin
        st_d = st_q;
        fb   = st_q.s[TAP_A] ^ st_q.s[TAP_B] ^ st_q.s[TAP_C] ^ st_q.s[TAP_D];
        if (adv_i) begin
            st_d.s = {st_q.s[SRC_W-2:0], fb};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.s <= SEED;
        end else begin
            st_q <= st_d;
        end
    end

    assign sample_o = $signed(st_q.s[SRC_W-1 -: OUT_W]);
    assign state_o  = st_q.s;
endmodule

// File: rtl/nz_onepole.sv
module nz_onepole #(
    parameter int unsigned DW = nz_pkg::NZ_OUT_W,
    parameter int unsigned CW = nz_pkg::NZ_COEF_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en_i,
    input  logic [CW-1:0]        alpha_i,
    input  logic signed [DW-1:0] x_i,
    output logic signed [DW-1:0] y_o,
    output logic                 vld_o
);
    localparam int unsigned PW = DW + CW + 3;
    localparam logic signed [PW-1:0] UNITY = {{(PW-CW-1){1'b0}}, 1'b1, {CW{1'b0}}};
    localparam logic signed [PW-1:0] HALF  = {{(PW-CW){1'b0}}, 1'b1, {(CW-1){1'b0}}};
    localparam logic signed [PW-1:0] MAXV  = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [PW-1:0] MINV  = {{(PW-DW+1){1'b1}}, {(DW-1){1'b0}}};

    typedef struct packed {
        logic signed [DW-1:0] y;
        logic                 vld;
    } filt_t;

    filt_t st_d, st_q;
    logic signed [PW-1:0] a_ext, b_ext, x_ext, y_ext, acc, rnd;

    always_comb begin
        st_d     = st_q;
        st_d.vld = en_i;
        a_ext    = PW'({1'b0, alpha_i});
        b_ext    = UNITY - a_ext;
        x_ext    = PW'(x_i);
        y_ext    = PW'(st_q.y);
        acc      = a_ext * x_ext + b_ext * y_ext;
        rnd      = (acc + HALF) >>> CW;
        if (en_i) begin
            if (rnd > MAXV) begin
                st_d.y = MAXV[DW-1:0];
            end else if (rnd < MINV) begin
                st_d.y = MINV[DW-1:0];
            end else begin
                st_d.y = rnd[DW-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.y   <= '0;
            st_q.vld <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign y_o   = st_q.y;
    assign vld_o = st_q.vld;
endmodule

// File: rtl/nz_filtered_noise.sv
module nz_filtered_noise #(
    parameter int unsigned OUT_W  = nz_pkg::NZ_OUT_W,
    parameter int unsigned COEF_W = nz_pkg::NZ_COEF_W,
    parameter int unsigned SRC_W  = nz_pkg::NZ_SRC_W,
    parameter logic [SRC_W-1:0] SEED = SRC_W'(nz_pkg::NZ_SEED)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sample_en,
    input  logic [COEF_W-1:0]       alpha,
    output logic signed [OUT_W-1:0] noise_o,
    output logic                    valid_o
);
    logic signed [OUT_W-1:0] white;
    logic [SRC_W-1:0]        src_state;

    nz_lfsr_src #(
        .SRC_W (SRC_W),
        .OUT_W (OUT_W),
        .SEED  (SEED)
    ) u_src (
        .clk      (clk),
        .rst      (rst),
        .adv_i    (sample_en),
        .sample_o (white),
        .state_o  (src_state)
    );

    nz_onepole #(
        .DW (OUT_W),
        .CW (COEF_W)
    ) u_filt (
        .clk     (clk),
        .rst     (rst),
        .en_i    (sample_en),
        .alpha_i (alpha),
        .x_i     (white),
        .y_o     (noise_o),
        .vld_o   (valid_o)
    );
endmodule

// File: rtl/nz_filtered_noise_chk.sv
module nz_filtered_noise_chk #(
    parameter int unsigned OUT_W  = 16,
    parameter int unsigned COEF_W = 16,
    parameter int unsigned SRC_W  = 32
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    sample_en,
    input logic [COEF_W-1:0]       alpha,
    input logic signed [OUT_W-1:0] noise_o,
    input logic                    valid_o,
    input logic [SRC_W-1:0]        src_state
);
    a_r1_src_nonzero: assert property (@(posedge clk) disable iff (rst)
        src_state != '0);

    a_r1_src_steps: assert property (@(posedge clk) disable iff (rst)
        sample_en |=> src_state != $past(src_state));

    a_r2_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (noise_o == '0 && !valid_o));

    a_r4_valid_after_strobe: assert property (@(posedge clk) disable iff (rst)
        sample_en |=> valid_o);

    a_r4_valid_low_idle: assert property (@(posedge clk) disable iff (rst)
        !sample_en |=> !valid_o);

    a_r5_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !sample_en |=> ($stable(noise_o) && $stable(src_state)));

    a_r6_zero_gain_hold: assert property (@(posedge clk) disable iff (rst)
        (sample_en && alpha == '0) |=> $stable(noise_o));
endmodule

bind nz_filtered_noise nz_filtered_noise_chk #(
    .OUT_W  (OUT_W),
    .COEF_W (COEF_W),
    .SRC_W  (SRC_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sample_en (sample_en),
    .alpha     (alpha),
    .noise_o   (noise_o),
    .valid_o   (valid_o),
    .src_state (src_state)
);

// File: tb/tb_nz_filtered_noise.sv
module tb_nz_filtered_noise;
    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              sample_en = 1'b0;
    logic [15:0]       alpha = '0;
    logic signed [15:0] noise_o;
    logic              valid_o;

    int total = 0;
    int bad   = 0;

    logic [31:0] m_src;
    longint      m_y;

    always #2 clk = ~clk;

    nz_filtered_noise dut (
        .clk       (clk),
        .rst       (rst),
        .sample_en (sample_en),
        .alpha     (alpha),
        .noise_o   (noise_o),
        .valid_o   (valid_o)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_src = 32'hACE1_2468;
        m_y   = 0;
    endtask

    // entered at a negedge; leaves at the next negedge after checking
    task automatic cyc(input logic en, input logic [15:0] a, input string tag);
        longint x, acc, r;
        sample_en = en;
        alpha     = a;
        if (en) begin
            x     = longint'($signed(m_src[31:16]));
            acc   = longint'(a) * x + (65536 - longint'(a)) * m_y;
            r     = (acc + 32768) >>> 16;
            if (r > 32767) r = 32767;
            if (r < -32768) r = -32768;
            m_y   = r;
            m_src = {m_src[30:0], m_src[31] ^ m_src[21] ^ m_src[1] ^ m_src[0]};
        end
        @(negedge clk);
        check({tag, " valid"}, longint'(valid_o), longint'(en));
        check({tag, " noise"}, longint'(noise_o), m_y);
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst = 1'b1;
        sample_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        check({tag, " reset noise"}, longint'(noise_o), 0);
        check({tag, " reset valid"}, longint'(valid_o), 0);
    endtask

    initial begin
        #800000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] sweep [6];
        sweep[0] = 16'h0001; sweep[1] = 16'h0100; sweep[2] = 16'h4000;
        sweep[3] = 16'h8000; sweep[4] = 16'hC000; sweep[5] = 16'hFFFF;

        do_reset("R2");
        // first strobe at near-unity gain exposes the seed (R1)
        cyc(1'b1, 16'hFFFF, "R1 seed sample");

        // coefficient sweep, strobe every cycle (R3, R1)
        for (int k = 0; k < 6; k++) begin
            for (int i = 0; i < 300; i++) begin
                cyc(1'b1, sweep[k], "R3 sweep");
            end
        end

        // gapped strobes (R4, R5)
        for (int i = 0; i < 300; i++) begin
            cyc((i % 3) != 0, 16'h2000, "R4 R5 gaps");
        end

        // zero gain: output holds, source keeps moving (R6)
        for (int i = 0; i < 64; i++) begin
            cyc(1'b1, 16'h0000, "R6 zero gain");
        end
        for (int i = 0; i < 64; i++) begin
            cyc(1'b1, 16'h8000, "R6 after zero gain");
        end

        // coefficient toggled on idle cycles only (R7)
        for (int i = 0; i < 400; i++) begin
            if (i % 2 == 0) begin
                cyc(1'b0, 16'(i * 37 + 5), "R7 idle coef");
            end else begin
                cyc(1'b1, 16'h3000, "R7 strobe coef");
            end
        end

        // mid-run reset restarts the sequence (R8)
        do_reset("R8");
        for (int i = 0; i < 200; i++) begin
            cyc(1'b1, 16'h1000, "R8 restart");
        end
        cyc(1'b0, 16'hFFFF, "R4 final idle");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule